// File: doc/BRIEF.md
# Cascaded Post Divider with Symmetric Output

This block divides one of several source clocks by a modulus picked from a fixed set of sixteen values and drives a single clock output whose high phase is exactly half its period, odd moduli included. The modulus is the product of three divider stages connected in cascade. Each stage counts the terminal counts of the stage before it, and a small lookup table expands the 4-bit selection code into the three stage moduli.

The duty-cycle shaping runs in the domain of the selected source. A rising-edge flag marks the first half of the overall count. For odd moduli, a copy of that flag is retimed on the falling edge and the two are ANDed, which trims half a source cycle from the high phase. Divide-by-one passes the source through a gate that is enabled on the falling edge.

Any change of code or source, and any release of power-down, restarts the cascade. The output is then held low for a full period of the new setting before the first new high phase. Power-down keeps the output low and every counter cleared.

Top module: `cascade_postdiv`

## Requirements
- R1: The output period is M cycles of the selected source, where M for codes 0 to 15 is 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 24, 32 in that order (code 0 divides by one).
- R2: M is realised as three cascaded stage counters. Each stage count stays below its own stage modulus, and all stages return to zero together at the end of each output period.
- R3: The output high time is exactly M/2 source cycles for every code, including the odd moduli 3, 5, 9 and 15.
- R4: `src_sel` value i (binary) selects bit i of `clk_src` as the source, and the output period scales with that source's period.
- R5: While `pwr_down` is 1, the output is low from the second source cycle after it is sampled, and it stays low.
- R6: After a change of `div_code` or `src_sel`, the first rising output edge comes no earlier than M_new cycles of the new source after the change.
- R7: After `pwr_down` returns to 0, the first rising output edge comes no earlier than M cycles of the source, and the output then runs at the R1/R3 timing.
- R8: The output is low while `rst_n` is 0. After reset, the first rising edge comes no earlier than M source cycles.
- R9: For code 0 the output follows the source with period T and high time T/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | NUM_SRC | Candidate source clocks |
| rst_n | input | 1 | Synchronous active-low reset, sampled by the selected source |
| div_code | input | 4 | Modulus selection code (see R1) |
| src_sel | input | SEL_W | Index of the source clock to divide |
| pwr_down | input | 1 | 1 stops the divider and holds the output low |
| clk_out | output | 1 | Divided clock with a symmetric duty cycle |

## Verification
The hardest case to reach is a reconfiguration while the old setting is between edges. The source clock changes, the cascade restarts and the mask window opens, and a stray high pulse of the old setting could be mistaken for a premature edge of the new one. The stimulus therefore waits for a falling output edge of an old setting whose modulus is at least four, so the old low phase covers the detection edge. It then switches code and source together to a clock of a different period and times the first new rising edge against M_new new-source periods. The odd-modulus high time of M/2 is measured at half-period resolution on every source, because only the falling-edge retimed flag can produce it.

// File: rtl/pdiv_pkg.sv
// Package: shared widths, stage-plan type and the code-to-stage lookup
// function used by the cascaded post divider.
package pdiv_pkg;

    localparam int NUM_STAGES = 3;   // cascaded divider stages
    localparam int STAGE_W    = 3;   // width of one stage modulus / count
    localparam int PROD_W     = 6;   // width holding the overall modulus
    localparam int CODE_W     = 4;   // width of the selection code

    typedef logic [STAGE_W-1:0] stage_mod_t;

    typedef struct packed {
        stage_mod_t [NUM_STAGES-1:0] mods;   // per-stage modulus, index 0 first
        logic [PROD_W-1:0]           prod;   // product of the three moduli
    } div_plan_t;

    // Expand a code into three stage moduli and their product.
    function automatic div_plan_t plan_of(input logic [CODE_W-1:0] code);
        stage_mod_t a, b, c;
        div_plan_t  pl;
        case (code)
            4'd0:    begin a = 3'd1; b = 3'd1; c = 3'd1; end
            4'd1:    begin a = 3'd2; b = 3'd1; c = 3'd1; end
            4'd2:    begin a = 3'd3; b = 3'd1; c = 3'd1; end
            4'd3:    begin a = 3'd2; b = 3'd2; c = 3'd1; end
            4'd4:    begin a = 3'd5; b = 3'd1; c = 3'd1; end
            4'd5:    begin a = 3'd2; b = 3'd3; c = 3'd1; end
            4'd6:    begin a = 3'd2; b = 3'd2; c = 3'd2; end
            4'd7:    begin a = 3'd3; b = 3'd3; c = 3'd1; end
            4'd8:    begin a = 3'd2; b = 3'd5; c = 3'd1; end
            4'd9:    begin a = 3'd2; b = 3'd2; c = 3'd3; end
            4'd10:   begin a = 3'd3; b = 3'd5; c = 3'd1; end
            4'd11:   begin a = 3'd4; b = 3'd2; c = 3'd2; end
            4'd12:   begin a = 3'd2; b = 3'd3; c = 3'd3; end
            4'd13:   begin a = 3'd4; b = 3'd5; c = 3'd1; end
            4'd14:   begin a = 3'd2; b = 3'd3; c = 3'd4; end
            default: begin a = 3'd4; b = 3'd4; c = 3'd2; end
        endcase
        pl.mods[0] = a;
        pl.mods[1] = b;
        pl.mods[2] = c;
        pl.prod    = PROD_W'(a) * PROD_W'(b) * PROD_W'(c);
        return pl;
    endfunction

endpackage

// File: rtl/pdiv_rom.sv
// pdiv_rom: combinational control lookup. Turns the applied code into the
// stage moduli and the overall modulus. Assumes the code is held stable
// by a register in the selected-source domain.
module pdiv_rom
    import pdiv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output div_plan_t         plan
);

    // Decode the applied code.
    always_comb begin
        plan = plan_of(code);
    end

endmodule

// File: rtl/pdiv_stage.sv
// pdiv_stage: one counter of the cascade. It advances on each enable,
// wraps at modulus-1 and flags the wrap so that the next stage can count it.
// Assumes a modulus of at least 1. A modulus of 1 wraps on every enable.
module pdiv_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    localparam logic [W-1:0] ONE = W'(1);

    // Terminal count of this stage, qualified by its enable.
    always_comb begin
        wrap = en && (cnt == W'(modulus - ONE));
    end

    // Count enables, clearing on reset, restart or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= wrap ? '0 : W'(cnt + ONE);
        end
    end

endmodule

// File: rtl/pdiv_ctrl.sv
// pdiv_ctrl: holds the applied code and source, detects a request that
// differs from them or a power-down, and runs the mask window. The window
// lasts prod+1 cycles of the new source before the cascade may run.
// Assumes it is clocked by the source that it itself selects.
module pdiv_ctrl
    import pdiv_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_req,
    input  logic [SEL_W-1:0]  sel_req,
    input  logic              pwr_down,
    input  logic [PROD_W-1:0] prod,
    output logic [CODE_W-1:0] app_code,
    output logic [SEL_W-1:0]  app_sel,
    output logic              mask_on,
    output logic              go
);

    logic              change;
    logic [PROD_W-1:0] mask_cnt;

    // A request differs from what is applied.
    always_comb begin
        change = (code_req != app_code) || (sel_req != app_sel);
        go     = !mask_on && !change && !pwr_down;
    end

    // Apply requests and time the mask window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_code <= '0;
            app_sel  <= '0;
            mask_on  <= 1'b1;
            mask_cnt <= '0;
        end else if (pwr_down || change) begin
            app_code <= code_req;
            app_sel  <= sel_req;
            mask_on  <= 1'b1;
            mask_cnt <= '0;
        end else if (mask_on) begin
            if (mask_cnt == prod) begin
                mask_on <= 1'b0;
            end else begin
                mask_cnt <= mask_cnt + PROD_W'(1);
            end
        end
    end

endmodule

// File: rtl/pdiv_shaper.sv
// pdiv_shaper: turns the cascade position into a symmetric output clock.
// Even moduli use a registered first-half flag. Odd moduli AND that flag
// with a falling-edge copy of it. Divide-by-one gates the source with an
// enable taken on the falling edge. Assumes the counts are zero whenever
// go is low.
module pdiv_shaper
    import pdiv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  stage_mod_t [NUM_STAGES-1:0] cnt,
    input  stage_mod_t [NUM_STAGES-1:0] mods,
    input  logic [PROD_W-1:0]           prod,
    output logic                        p_div,
    output logic                        p_one,
    output logic                        clk_out
);

    logic [PROD_W-1:0] phase;
    logic [PROD_W-1:0] weight;
    logic [PROD_W-1:0] half;
    logic              is_one;
    logic              is_odd;
    logic              n_div;
    logic              n_one;

    // Mixed-radix position within the overall period.
    always_comb begin
        phase  = '0;
        weight = PROD_W'(1);
        for (int k = 0; k < NUM_STAGES; k++) begin
            phase  = phase + weight * PROD_W'(cnt[k]);
            weight = weight * PROD_W'(mods[k]);
        end
        half   = (prod + PROD_W'(1)) >> 1;
        is_one = (prod == PROD_W'(1));
        is_odd = prod[0];
    end

    // Rising-edge first-half flag and divide-by-one enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_div <= 1'b0;
            p_one <= 1'b0;
        end else begin
            p_div <= go && !is_one && (phase < half);
            p_one <= go && is_one;
        end
    end

    // Falling-edge retimed copies of the flags.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            n_div <= 1'b0;
            n_one <= 1'b0;
        end else begin
            n_div <= p_div;
            n_one <= p_one;
        end
    end

    // Combine the flags into the output clock.
    always_comb begin
        clk_out = (p_div && (is_odd ? n_div : 1'b1)) || (clk && n_one);
    end

endmodule

// File: rtl/cascade_postdiv.sv
// cascade_postdiv: top of the cascaded post divider. It selects a source
// clock, runs three cascaded stage counters from the applied code and shapes
// a symmetric output. Assumes every source is free running while rst_n is
// low, so that the synchronous reset is seen by the selected source.
module cascade_postdiv
    import pdiv_pkg::*;
#(
    parameter  int NUM_SRC = 4,
    localparam int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] clk_src,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  div_code,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               pwr_down,
    output logic               clk_out
);

    logic                        clk_sel;
    logic [CODE_W-1:0]           app_code;
    logic [SEL_W-1:0]            app_sel;
    logic                        mask_on;
    logic                        go;
    div_plan_t                   plan;
    logic [NUM_STAGES-1:0]       stg_en;
    logic [NUM_STAGES-1:0]       stg_wrap;
    stage_mod_t [NUM_STAGES-1:0] stg_cnt;
    logic                        p_div;
    logic                        p_one;

    // Source selection from the applied index.
    always_comb begin
        clk_sel = clk_src[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (app_sel == SEL_W'(i)) begin
                clk_sel = clk_src[i];
            end
        end
    end

    pdiv_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk      (clk_sel),
        .rst_n    (rst_n),
        .code_req (div_code),
        .sel_req  (src_sel),
        .pwr_down (pwr_down),
        .prod     (plan.prod),
        .app_code (app_code),
        .app_sel  (app_sel),
        .mask_on  (mask_on),
        .go       (go)
    );

    pdiv_rom u_rom (
        .code (app_code),
        .plan (plan)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign stg_en[k] = go;
        end else begin : g_next
            assign stg_en[k] = stg_wrap[k-1];
        end
        pdiv_stage #(.W(STAGE_W)) u_stg (
            .clk     (clk_sel),
            .rst_n   (rst_n),
            .clr     (!go),
            .en      (stg_en[k]),
            .modulus (plan.mods[k]),
            .cnt     (stg_cnt[k]),
            .wrap    (stg_wrap[k])
        );
    end

    pdiv_shaper u_shape (
        .clk     (clk_sel),
        .rst_n   (rst_n),
        .go      (go),
        .cnt     (stg_cnt),
        .mods    (plan.mods),
        .prod    (plan.prod),
        .p_div   (p_div),
        .p_one   (p_one),
        .clk_out (clk_out)
    );

endmodule

// File: rtl/pdiv_chk.sv
// pdiv_chk: property checker for cascade_postdiv, bound to every instance.
// Assumes clk is the selected source clock.
module pdiv_chk
    import pdiv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pwr_down,
    input  logic                        clk_out,
    input  logic                        mask_on,
    input  logic                        p_div,
    input  logic                        p_one,
    input  logic [NUM_STAGES-1:0]       stg_wrap,
    input  stage_mod_t [NUM_STAGES-1:0] stg_cnt,
    input  stage_mod_t [NUM_STAGES-1:0] stg_mod
);

    // R2: every stage count stays below its own modulus.
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_rng
        p_stage_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
            stg_cnt[k] < stg_mod[k]);
    end

    // R2: a wrap of the last stage returns the whole cascade to zero.
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stg_wrap[NUM_STAGES-1] |=> (stg_cnt == '0));

    // R5: one sampled power-down cycle leaves the output low.
    p_pd_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> !clk_out);

    // R6: inside the mask window neither output flag is raised.
    p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_on |=> (!p_div && !p_one));

    // R6: the first-half flag can only rise once the cascade is running.
    p_rise_after_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_div) |-> !$past(mask_on));

endmodule

bind cascade_postdiv pdiv_chk u_chk (
    .clk      (clk_sel),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .clk_out  (clk_out),
    .mask_on  (mask_on),
    .p_div    (p_div),
    .p_one    (p_one),
    .stg_wrap (stg_wrap),
    .stg_cnt  (stg_cnt),
    .stg_mod  (plan.mods)
);

// File: tb/sim_cascade_postdiv.sv
`timescale 1ns/100ps
module sim_cascade_postdiv;

    typedef struct {
        real   period;
        real   high;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic [3:0] clk_src;
    logic       s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] div_code = 4'd4;
    logic [1:0] src_sel = 2'd0;
    logic       pwr_down = 1'b0;
    logic       clk_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  armed = 0;
    bit  have_rise = 0;
    real last_rise = 0.0;
    real last_high = 0.0;
    exp_t sb[$];

    always #5  clk = ~clk;
    always #7  s1  = ~s1;
    always #3  s2  = ~s2;
    always #13 s3  = ~s3;
    assign clk_src = {s3, s2, s1, clk};

    cascade_postdiv u0 (
        .clk_src  (clk_src),
        .rst_n    (rst_n),
        .div_code (div_code),
        .src_sel  (src_sel),
        .pwr_down (pwr_down),
        .clk_out  (clk_out)
    );

    function automatic int mod_of(int code);
        case (code)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 9;
            8: return 10;  9: return 12;  10: return 15; 11: return 16;
            12: return 18; 13: return 20; 14: return 24; default: return 32;
        endcase
    endfunction

    function automatic real per_of(int sel);
        case (sel)
            0: return 10.0;
            1: return 14.0;
            2: return 6.0;
            default: return 26.0;
        endcase
    endfunction

    task automatic check(bit ok, string req, real act, real exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
        end
    endtask

    // Monitor: pop expected periods and compare on each rising edge.
    always @(posedge clk_out) begin
        if (armed) begin
            if (have_rise && sb.size() > 0) begin
                exp_t e;
                real  p;
                e = sb.pop_front();
                p = $realtime - last_rise;
                check((p > e.period - 0.01) && (p < e.period + 0.01),
                      {e.tag, " period"}, p, e.period);
                check((last_high > e.high - 0.01) && (last_high < e.high + 0.01),
                      {e.tag, " high time"}, last_high, e.high);
            end
            last_rise = $realtime;
            have_rise = 1;
        end
    end

    always @(negedge clk_out) begin
        if (armed && have_rise) last_high = $realtime - last_rise;
    end

    task automatic apply(int code, int sel, bit pd);
        div_code = 4'(code);
        src_sel  = 2'(sel);
        pwr_down = pd;
    endtask

    // Driver: push expected periods, then wait for the monitor to drain them.
    task automatic measure(string tag, int code, int sel, int n);
        real t;
        int  guard;
        t = per_of(sel);
        have_rise = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.period = mod_of(code) * t;
            e.high   = mod_of(code) * t / 2.0;
            e.tag    = tag;
            sb.push_back(e);
        end
        armed = 1;
        guard = 0;
        while (sb.size() > 0 && guard < 40000) begin
            #0.5;
            guard++;
        end
        if (sb.size() > 0) begin
            check(0, {tag, " no output edges"}, real'(sb.size()), 0.0);
            sb.delete();
        end
        armed = 0;
    endtask

    task automatic settle(int code, int sel);
        #(3.0 * mod_of(code) * per_of(sel) + 300.0);
    endtask

    // Time from now until the next rising output edge, by polling.
    task automatic time_to_rise(output real dt);
        real t0;
        int  guard;
        t0 = $realtime;
        guard = 0;
        while (clk_out !== 1'b1 && guard < 40000) begin
            #0.5;
            guard++;
        end
        dt = $realtime - t0 - 0.5;
    endtask

    task automatic mask_case(string tag, int c0, int s0, int c1, int s1n);
        real dt;
        real lim;
        apply(c0, s0, 0);
        settle(c0, s0);
        @(negedge clk_out);
        #0.5;
        apply(c1, s1n, 0);
        time_to_rise(dt);
        lim = mod_of(c1) * per_of(s1n);
        check(dt >= lim, tag, dt, lim);
        settle(c1, s1n);
        measure({tag, " steady"}, c1, s1n, 2);
    endtask

    initial begin
        #2000000;
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int  highs;
        real dt;
        // R8: output low throughout reset.
        highs = 0;
        for (int i = 0; i < 400; i++) begin
            #0.5;
            if (clk_out === 1'b1) highs++;
        end
        check(highs == 0, "R8 low in reset", real'(highs), 0.0);
        #0.5;
        rst_n = 1'b1;
        time_to_rise(dt);
        check(dt >= 50.0, "R8 first rise after reset", dt, 50.0);

        // R9: divide by one follows the source.
        apply(0, 0, 0);
        settle(0, 0);
        measure("R9 bypass", 0, 0, 3);

        // R1 / R3: every code on source 0.
        for (int c = 1; c < 16; c++) begin
            apply(c, 0, 0);
            settle(c, 0);
            measure("R1/R3 code sweep", c, 0, 2);
        end

        // R4: other sources, odd and even moduli.
        for (int s = 1; s < 4; s++) begin
            apply(4, s, 0);
            settle(4, s);
            measure("R4 odd on source", 4, s, 2);
            apply(9, s, 0);
            settle(9, s);
            measure("R4 even on source", 9, s, 2);
        end
        apply(0, 2, 0);
        settle(0, 2);
        measure("R4 bypass source 2", 0, 2, 2);

        // R6: reconfiguration masks the output for a new period.
        mask_case("R6 code and source change", 5, 0, 8, 1);
        mask_case("R6 source change odd", 6, 2, 7, 3);
        mask_case("R6 code change only", 3, 3, 10, 3);

        // R5: power-down holds the output low.
        apply(7, 0, 0);
        settle(7, 0);
        apply(7, 0, 1);
        #60.5;
        highs = 0;
        for (int i = 0; i < 1200; i++) begin
            #0.5;
            if (clk_out === 1'b1) highs++;
        end
        check(highs == 0, "R5 low while powered down", real'(highs), 0.0);

        // R7: release from power-down.
        apply(7, 0, 0);
        time_to_rise(dt);
        check(dt >= 90.0, "R7 first rise after power-up", dt, 90.0);
        settle(7, 0);
        measure("R7 steady after power-up", 7, 0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule